// File: doc/BRIEF.md
# Block-Granular Logical-to-Physical Remapper

This block keeps the translation from logical block numbers to physical flash blocks for a storage controller that maps whole erase blocks. A request carries a sector address; the in-block sector offset bits are discarded and the remaining upper bits select the logical block. A lookup returns the physical block currently holding that logical block. A rewrite never touches the current physical block. It draws a spare block from a pool of free blocks and hands it to an external erase/program engine. When the engine reports completion, the table entry is redirected to the spare and the previous block goes to the back of the pool.

After reset an initialisation walk writes the identity mapping for the logical range and loads the pool with the physical blocks above it. Lookups are accepted whenever initialisation is over, including while a rewrite is in flight. At most one rewrite is in flight at a time. Rewrite requests that arrive while the pool is empty are answered with an error and change nothing.

Top module: `blk_remap`

## Requirements
- R1: After reset release, `lk_ready` and `rw_ready` stay low for exactly NUM_PHYS cycles and then rise. Logical block i then maps to physical block i.
- R2: The logical block is the sector address with its low SECT_OFF_W bits removed. All sectors of one logical block return the same physical block.
- R3: An accepted lookup (`req_valid`, `req_op`=0, `lk_ready`) raises `rsp_lk_valid` for exactly one cycle, on the next cycle. `rsp_lk_valid` is never raised without an accepted lookup.
- R4: An accepted rewrite (`req_op`=1, `rw_ready`, pool not empty) takes the block at the head of the pool. On the next cycle `eng_start` is high for one cycle, and `eng_blk` carries that block. After reset the pool holds NUM_LOG, NUM_LOG+1, … NUM_PHYS-1 in that order.
- R5: The table entry changes only at the clock edge that samples `eng_done`. Lookups of the rewritten block up to and including that edge return the old block. Later lookups return the new one.
- R6: The retired physical block is appended at the tail of the pool, so it is handed out again only after every block that was already free.
- R7: A rewrite accepted while the pool is empty gets `rsp_rw_valid` with `rsp_rw_err`=1 on the next cycle. No `eng_start` follows, and the table is unchanged.
- R8: `rw_ready` is low from the cycle after a successful rewrite acceptance until the cycle after its completion. Rewrite requests made while it is low are ignored: no engine start and no response.
- R9: One cycle after `eng_done` is sampled during a rewrite, `rsp_rw_valid` is high with `rsp_rw_err`=0 and `rsp_rw_phys` equal to the new physical block.
- R10: `eng_done` asserted while no rewrite is in flight produces no response and does not alter the table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_op | input | 1 | 0 = lookup, 1 = rewrite |
| req_sector | input | LOG_W+SECT_OFF_W | Sector address of the request |
| lk_ready | output | 1 | Lookups accepted (initialisation complete) |
| rw_ready | output | 1 | Rewrites accepted (idle, initialisation complete) |
| rsp_lk_valid | output | 1 | Lookup response valid |
| rsp_lk_phys | output | PHYS_W | Physical block returned by a lookup |
| rsp_rw_valid | output | 1 | Rewrite finished or rejected |
| rsp_rw_err | output | 1 | Rewrite rejected because the pool was empty |
| rsp_rw_phys | output | PHYS_W | New physical block of a finished rewrite |
| eng_start | output | 1 | One-cycle command to erase/program `eng_blk` |
| eng_blk | output | PHYS_W | Physical block given to the engine |
| eng_done | input | 1 | Engine completion pulse |

## Verification
Lookups sweep every logical block with different in-block sector offsets, which shows whether the offset bits are truly discarded and whether the identity load is correct. Rewrites are run with engine delays of different lengths. Same-block lookups are interleaved while the rewrite is pending, and one lookup lands on the very completion edge; this separates an early table update from a correct post-completion swap. A chain of rewrites that drains the initial free blocks shows whether retired blocks join the tail or the head of the pool. A second instance without spare blocks, together with stray completion pulses and rewrite attempts while busy, exercises the rejection and ignore paths.

// File: rtl/blk_remap_pkg.sv
package blk_remap_pkg;
  localparam logic OP_LOOKUP  = 1'b0;
  localparam logic OP_REWRITE = 1'b1;

  typedef enum logic [1:0] {
    ST_INIT = 2'd0,
    ST_IDLE = 2'd1,
    ST_WAIT = 2'd2
  } remap_state_e;
endpackage

// File: rtl/blk_remap_table.sv
// Logical-to-physical map: one read-only port for lookups, one read/write
// port for the rewrite sequencer. Written without reset so it maps to RAM.
module blk_remap_table #(
  parameter int ENTRIES = 8,
  parameter int AW      = 3,
  parameter int DW      = 4
) (
  input  logic          clk,
  input  logic          a_re,
  input  logic [AW-1:0] a_addr,
  output logic [DW-1:0] a_q,
  input  logic          b_we,
  input  logic          b_re,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_wd,
  output logic [DW-1:0] b_q
);
  logic [DW-1:0] mem [ENTRIES];

  // Port A: registered read, read-first against a same-edge port B write.
  always_ff @(posedge clk) begin
    if (a_re) a_q <= mem[a_addr];
  end

  // Port B: write or registered read.
  always_ff @(posedge clk) begin
    if (b_we) mem[b_addr] <= b_wd;
    if (b_re) b_q <= mem[b_addr];
  end
endmodule

// File: rtl/blk_remap_fifo.sv
// Free-block pool: circular FIFO with the head visible in the same cycle.
module blk_remap_fifo #(
  parameter int DEPTH = 4,
  parameter int DW    = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic          empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] fill;

  function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else begin
      if (push) wr_ptr <= ptr_next(wr_ptr);
      if (pop)  rd_ptr <= ptr_next(rd_ptr);
      fill <= fill + CW'(push) - CW'(pop);
    end
  end

  assign head  = mem[rd_ptr];
  assign empty = (fill == '0);
endmodule

// File: rtl/blk_remap_ctrl.sv
// Initialisation walk, lookup acceptance and the single-outstanding
// rewrite sequence (take spare, erase/program, swap, recycle).
module blk_remap_ctrl
  import blk_remap_pkg::*;
#(
  parameter int NUM_LOG  = 8,
  parameter int NUM_PHYS = 12,
  parameter int LOG_W    = 3,
  parameter int PHYS_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_op,
  input  logic [LOG_W-1:0]  req_log,
  input  logic              eng_done,
  input  logic [PHYS_W-1:0] fifo_head,
  input  logic              fifo_empty,
  input  logic [PHYS_W-1:0] tbl_b_q,
  output logic              lk_ready,
  output logic              rw_ready,
  output logic              rsp_lk_valid,
  output logic              rsp_rw_valid,
  output logic              rsp_rw_err,
  output logic [PHYS_W-1:0] rsp_rw_phys,
  output logic              eng_start,
  output logic [PHYS_W-1:0] eng_blk,
  output logic              tbl_a_re,
  output logic              tbl_b_we,
  output logic              tbl_b_re,
  output logic [LOG_W-1:0]  tbl_b_addr,
  output logic [PHYS_W-1:0] tbl_b_wd,
  output logic              fifo_push,
  output logic [PHYS_W-1:0] fifo_push_data,
  output logic              fifo_pop
);
  localparam int CNT_W = $clog2(NUM_PHYS + 1);

  remap_state_e      state;
  logic [CNT_W-1:0]  init_cnt;
  logic [LOG_W-1:0]  cur_log;
  logic [PHYS_W-1:0] new_blk;

  logic lk_acc, rw_acc, rw_take, init_tbl, init_pool, commit;

  assign lk_ready = (state != ST_INIT);
  assign rw_ready = (state == ST_IDLE);

  assign lk_acc  = req_valid && (req_op == OP_LOOKUP)  && lk_ready;
  assign rw_acc  = req_valid && (req_op == OP_REWRITE) && rw_ready;
  assign rw_take = rw_acc && !fifo_empty;
  assign commit  = (state == ST_WAIT) && eng_done;

  assign init_tbl  = (state == ST_INIT) && (init_cnt <  CNT_W'(NUM_LOG));
  assign init_pool = (state == ST_INIT) && (init_cnt >= CNT_W'(NUM_LOG));

  // Datapath steering for table port B and the pool.
  always_comb begin
    tbl_a_re       = lk_acc;
    tbl_b_we       = 1'b0;
    tbl_b_re       = 1'b0;
    tbl_b_addr     = req_log;
    tbl_b_wd       = new_blk;
    fifo_push      = 1'b0;
    fifo_push_data = tbl_b_q;
    fifo_pop       = 1'b0;
    if (init_tbl) begin
      tbl_b_we   = 1'b1;
      tbl_b_addr = init_cnt[LOG_W-1:0];
      tbl_b_wd   = init_cnt[PHYS_W-1:0];
    end else if (init_pool) begin
      fifo_push      = 1'b1;
      fifo_push_data = init_cnt[PHYS_W-1:0];
    end else if (rw_take) begin
      fifo_pop = 1'b1;
      tbl_b_re = 1'b1;
    end else if (commit) begin
      tbl_b_we   = 1'b1;
      tbl_b_addr = cur_log;
      fifo_push  = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_INIT;
      init_cnt     <= '0;
      cur_log      <= '0;
      new_blk      <= '0;
      rsp_lk_valid <= 1'b0;
      rsp_rw_valid <= 1'b0;
      rsp_rw_err   <= 1'b0;
      rsp_rw_phys  <= '0;
      eng_start    <= 1'b0;
      eng_blk      <= '0;
    end else begin
      rsp_lk_valid <= lk_acc;
      rsp_rw_valid <= 1'b0;
      rsp_rw_err   <= 1'b0;
      eng_start    <= 1'b0;
      case (state)
        ST_INIT: begin
          if (init_cnt == CNT_W'(NUM_PHYS - 1)) state <= ST_IDLE;
          init_cnt <= init_cnt + 1'b1;
        end
        ST_IDLE: begin
          if (rw_acc) begin
            if (fifo_empty) begin
              rsp_rw_valid <= 1'b1;
              rsp_rw_err   <= 1'b1;
              rsp_rw_phys  <= '0;
            end else begin
              state     <= ST_WAIT;
              cur_log   <= req_log;
              new_blk   <= fifo_head;
              eng_start <= 1'b1;
              eng_blk   <= fifo_head;
            end
          end
        end
        ST_WAIT: begin
          if (eng_done) begin
            state        <= ST_IDLE;
            rsp_rw_valid <= 1'b1;
            rsp_rw_phys  <= new_blk;
          end
        end
        default: state <= ST_INIT;
      endcase
    end
  end
endmodule

// File: rtl/blk_remap.sv
module blk_remap #(
  parameter int NUM_LOG    = 8,
  parameter int NUM_PHYS   = 12,
  parameter int SECT_OFF_W = 3,
  parameter int LOG_W      = $clog2(NUM_LOG),
  parameter int PHYS_W     = $clog2(NUM_PHYS),
  parameter int SEC_W      = LOG_W + SECT_OFF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_op,
  input  logic [SEC_W-1:0]  req_sector,
  output logic              lk_ready,
  output logic              rw_ready,
  output logic              rsp_lk_valid,
  output logic [PHYS_W-1:0] rsp_lk_phys,
  output logic              rsp_rw_valid,
  output logic              rsp_rw_err,
  output logic [PHYS_W-1:0] rsp_rw_phys,
  output logic              eng_start,
  output logic [PHYS_W-1:0] eng_blk,
  input  logic              eng_done
);
  localparam int FREE_N = NUM_PHYS - NUM_LOG;
  localparam int POOL_D = (FREE_N > 0) ? FREE_N : 1;

  logic [LOG_W-1:0]  req_log;
  logic              tbl_a_re, tbl_b_we, tbl_b_re;
  logic [LOG_W-1:0]  tbl_b_addr;
  logic [PHYS_W-1:0] tbl_b_wd, tbl_b_q;
  logic              fifo_push, fifo_pop, fifo_empty;
  logic [PHYS_W-1:0] fifo_push_data, fifo_head;

  // Sector offset within the block is dropped.
  assign req_log = req_sector[SEC_W-1:SECT_OFF_W];

  blk_remap_table #(.ENTRIES(NUM_LOG), .AW(LOG_W), .DW(PHYS_W)) u_table (
    .clk    (clk),
    .a_re   (tbl_a_re),
    .a_addr (req_log),
    .a_q    (rsp_lk_phys),
    .b_we   (tbl_b_we),
    .b_re   (tbl_b_re),
    .b_addr (tbl_b_addr),
    .b_wd   (tbl_b_wd),
    .b_q    (tbl_b_q)
  );

  blk_remap_fifo #(.DEPTH(POOL_D), .DW(PHYS_W)) u_pool (
    .clk       (clk),
    .rst       (rst),
    .push      (fifo_push),
    .push_data (fifo_push_data),
    .pop       (fifo_pop),
    .head      (fifo_head),
    .empty     (fifo_empty)
  );

  blk_remap_ctrl #(
    .NUM_LOG(NUM_LOG), .NUM_PHYS(NUM_PHYS), .LOG_W(LOG_W), .PHYS_W(PHYS_W)
  ) u_ctrl (
    .clk            (clk),
    .rst            (rst),
    .req_valid      (req_valid),
    .req_op         (req_op),
    .req_log        (req_log),
    .eng_done       (eng_done),
    .fifo_head      (fifo_head),
    .fifo_empty     (fifo_empty),
    .tbl_b_q        (tbl_b_q),
    .lk_ready       (lk_ready),
    .rw_ready       (rw_ready),
    .rsp_lk_valid   (rsp_lk_valid),
    .rsp_rw_valid   (rsp_rw_valid),
    .rsp_rw_err     (rsp_rw_err),
    .rsp_rw_phys    (rsp_rw_phys),
    .eng_start      (eng_start),
    .eng_blk        (eng_blk),
    .tbl_a_re       (tbl_a_re),
    .tbl_b_we       (tbl_b_we),
    .tbl_b_re       (tbl_b_re),
    .tbl_b_addr     (tbl_b_addr),
    .tbl_b_wd       (tbl_b_wd),
    .fifo_push      (fifo_push),
    .fifo_push_data (fifo_push_data),
    .fifo_pop       (fifo_pop)
  );
endmodule

// File: rtl/blk_remap_chk.sv
module blk_remap_chk (
  input logic clk,
  input logic rst,
  input logic req_valid,
  input logic req_op,
  input logic lk_ready,
  input logic rw_ready,
  input logic rsp_lk_valid,
  input logic rsp_rw_valid,
  input logic rsp_rw_err,
  input logic eng_start,
  input logic eng_done
);
  logic lk_fire, rw_fire;
  assign lk_fire = req_valid && !req_op && lk_ready;
  assign rw_fire = req_valid &&  req_op && rw_ready;

  assert_init_gate_R1: assert property (@(posedge clk) disable iff (rst)
    !lk_ready |-> !rw_ready);

  assert_lk_answer_R3: assert property (@(posedge clk) disable iff (rst)
    lk_fire |=> rsp_lk_valid);

  assert_lk_no_spurious_R3: assert property (@(posedge clk) disable iff (rst)
    !lk_fire |=> !rsp_lk_valid);

  assert_start_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    eng_start |=> !eng_start);

  assert_err_with_valid_R7: assert property (@(posedge clk) disable iff (rst)
    rsp_rw_err |-> rsp_rw_valid);

  assert_busy_after_take_R8: assert property (@(posedge clk) disable iff (rst)
    rw_fire |=> (!rw_ready || rsp_rw_err));

  assert_start_while_busy_R8: assert property (@(posedge clk) disable iff (rst)
    eng_start |-> !rw_ready);

  assert_commit_follows_done_R9: assert property (@(posedge clk) disable iff (rst)
    (rsp_rw_valid && !rsp_rw_err) |-> ($past(eng_done) && !$past(rw_ready)));

  assert_stray_done_R10: assert property (@(posedge clk) disable iff (rst)
    (rw_ready && eng_done) |=> !(rsp_rw_valid && !rsp_rw_err));
endmodule

bind blk_remap blk_remap_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .req_valid    (req_valid),
  .req_op       (req_op),
  .lk_ready     (lk_ready),
  .rw_ready     (rw_ready),
  .rsp_lk_valid (rsp_lk_valid),
  .rsp_rw_valid (rsp_rw_valid),
  .rsp_rw_err   (rsp_rw_err),
  .eng_start    (eng_start),
  .eng_done     (eng_done)
);

// File: tb/blk_remap_bench.sv
module blk_remap_bench;
  localparam int NL  = 8;
  localparam int NP  = 12;
  localparam int OFF = 3;
  localparam int LW  = 3;
  localparam int PW  = 4;
  localparam int SW  = LW + OFF;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst = 1'b1;
  logic          req_valid = 1'b0, req_op = 1'b0, eng_done = 1'b0;
  logic [SW-1:0] req_sector = '0;
  logic          lk_ready, rw_ready, rsp_lk_valid, rsp_rw_valid, rsp_rw_err, eng_start;
  logic [PW-1:0] rsp_lk_phys, rsp_rw_phys, eng_blk;

  blk_remap #(.NUM_LOG(NL), .NUM_PHYS(NP), .SECT_OFF_W(OFF)) u_blk_remap (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_sector(req_sector), .lk_ready(lk_ready), .rw_ready(rw_ready),
    .rsp_lk_valid(rsp_lk_valid), .rsp_lk_phys(rsp_lk_phys),
    .rsp_rw_valid(rsp_rw_valid), .rsp_rw_err(rsp_rw_err),
    .rsp_rw_phys(rsp_rw_phys), .eng_start(eng_start), .eng_blk(eng_blk),
    .eng_done(eng_done));

  // Second instance without spare blocks for the empty-pool case.
  logic          nf_valid = 1'b0, nf_op = 1'b0;
  logic [SW-1:0] nf_sector = '0;
  logic          nf_lk_ready, nf_rw_ready, nf_lk_valid, nf_rw_valid, nf_rw_err, nf_start;
  logic [2:0]    nf_lk_phys, nf_rw_phys, nf_blk;

  blk_remap #(.NUM_LOG(NL), .NUM_PHYS(NL), .SECT_OFF_W(OFF)) u_blk_remap_nospare (
    .clk(clk), .rst(rst), .req_valid(nf_valid), .req_op(nf_op),
    .req_sector(nf_sector), .lk_ready(nf_lk_ready), .rw_ready(nf_rw_ready),
    .rsp_lk_valid(nf_lk_valid), .rsp_lk_phys(nf_lk_phys),
    .rsp_rw_valid(nf_rw_valid), .rsp_rw_err(nf_rw_err),
    .rsp_rw_phys(nf_rw_phys), .eng_start(nf_start), .eng_blk(nf_blk),
    .eng_done(1'b0));

  int n_chk = 0, n_fail = 0;
  int map_m [NL];
  int free_q [$];
  int lk_q [$];
  string tag_q [$];
  int exp_starts = 0, seen_starts = 0, exp_rw = 0, seen_rw = 0;
  logic lk_fire_d = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // Scoreboard monitor: lookup responses popped in order.
  always @(posedge clk) lk_fire_d <= req_valid && !req_op && lk_ready;

  always @(negedge clk) begin
    if (!rst) begin
      if (rsp_lk_valid || lk_fire_d)
        check(rsp_lk_valid == lk_fire_d, "R3 lookup answered next cycle",
              int'(rsp_lk_valid), int'(lk_fire_d));
      if (rsp_lk_valid && lk_q.size() > 0) begin
        int e;
        string t;
        e = lk_q.pop_front();
        t = tag_q.pop_front();
        check(int'(rsp_lk_phys) == e, t, int'(rsp_lk_phys), e);
      end
      if (eng_start) seen_starts++;
      if (rsp_rw_valid) seen_rw++;
    end
  end

  // Driver: called right after a falling edge.
  task automatic drive_lookup(input int lg, input int off, input string tag);
    req_valid  = 1'b1;
    req_op     = 1'b0;
    req_sector = {lg[LW-1:0], off[OFF-1:0]};
    lk_q.push_back(map_m[lg]);
    tag_q.push_back(tag);
  endtask

  task automatic lookup_all(input int off, input string tag);
    for (int i = 0; i < NL; i++) begin
      @(negedge clk);
      drive_lookup(i, off + i, tag);
    end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic rewrite(input int lg, input int delay, input bit probe);
    int exp_new, old;
    @(negedge clk);
    check(rw_ready == 1'b1, "R8 ready before rewrite", int'(rw_ready), 1);
    exp_new    = free_q[0];
    req_valid  = 1'b1;
    req_op     = 1'b1;
    req_sector = {lg[LW-1:0], 3'd5};
    @(negedge clk);
    req_valid = 1'b0;
    check(eng_start == 1'b1, "R4 engine started", int'(eng_start), 1);
    check(int'(eng_blk) == exp_new, "R4 spare from pool head", int'(eng_blk), exp_new);
    check(rw_ready == 1'b0, "R8 busy during rewrite", int'(rw_ready), 0);
    exp_starts++;
    for (int i = 0; i < delay; i++) begin
      if (probe) begin
        if (i % 2 == 0) drive_lookup(lg, i, "R5 old mapping while pending");
        else begin
          req_valid  = 1'b1;
          req_op     = 1'b1;
          req_sector = {lg[LW-1:0] + 3'd1, 3'd0};
        end
      end
      @(negedge clk);
      req_valid = 1'b0;
      if (i == 0) check(eng_start == 1'b0, "R4 start is one pulse", int'(eng_start), 0);
      check(rsp_rw_valid == 1'b0, "R5 no completion before done", int'(rsp_rw_valid), 0);
    end
    eng_done = 1'b1;
    if (probe) drive_lookup(lg, 7, "R5 old mapping on commit edge");
    @(negedge clk);
    eng_done  = 1'b0;
    req_valid = 1'b0;
    check(rsp_rw_valid && !rsp_rw_err, "R9 completion response",
          int'({rsp_rw_valid, rsp_rw_err}), 2);
    check(int'(rsp_rw_phys) == exp_new, "R9 new block reported", int'(rsp_rw_phys), exp_new);
    check(rw_ready == 1'b1, "R8 ready after completion", int'(rw_ready), 1);
    exp_rw++;
    old = map_m[lg];
    map_m[lg] = exp_new;
    void'(free_q.pop_front());
    free_q.push_back(old);
  endtask

  initial begin
    int cyc;
    for (int i = 0; i < NL; i++) map_m[i] = i;
    for (int i = NL; i < NP; i++) free_q.push_back(i);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(!lk_ready && !rw_ready && !rsp_lk_valid && !rsp_rw_valid && !eng_start,
          "R1 reset state", int'(lk_ready), 0);
    cyc = 0;
    while (!lk_ready && cyc < 40) begin
      @(negedge clk);
      cyc++;
    end
    check(cyc == NP, "R1 init length", cyc, NP);
    check(rw_ready == 1'b1, "R1 rewrite ready after init", int'(rw_ready), 1);

    lookup_all(0, "R1 identity after init");
    lookup_all(3, "R2 offset ignored");

    rewrite(3, 4, 1'b1);
    @(negedge clk);
    drive_lookup(3, 2, "R5 new mapping after commit");
    @(negedge clk);
    req_valid = 1'b0;

    rewrite(0, 1, 1'b0);
    rewrite(1, 0, 1'b0);
    rewrite(2, 6, 1'b1);
    rewrite(5, 2, 1'b0);
    check(map_m[5] == 3, "R6 retired block recycled from tail", map_m[5], 3);
    rewrite(6, 3, 1'b1);

    @(negedge clk);
    eng_done = 1'b1;
    @(negedge clk);
    eng_done = 1'b0;
    check(rsp_rw_valid == 1'b0, "R10 stray done ignored", int'(rsp_rw_valid), 0);
    lookup_all(1, "R10 table intact");

    @(negedge clk);
    nf_valid  = 1'b1;
    nf_op     = 1'b1;
    nf_sector = {3'd2, 3'd4};
    @(negedge clk);
    nf_valid = 1'b0;
    check(nf_rw_valid && nf_rw_err, "R7 empty pool rejected",
          int'({nf_rw_valid, nf_rw_err}), 3);
    check(nf_start == 1'b0, "R7 no engine start", int'(nf_start), 0);
    @(negedge clk);
    nf_valid  = 1'b1;
    nf_op     = 1'b0;
    nf_sector = {3'd2, 3'd1};
    @(negedge clk);
    nf_valid = 1'b0;
    check(nf_lk_valid && nf_lk_phys == 3'd2, "R7 table unchanged",
          int'(nf_lk_phys), 2);

    repeat (4) @(negedge clk);
    check(seen_starts == exp_starts, "R8 no extra engine starts", seen_starts, exp_starts);
    check(seen_rw == exp_rw, "R8 no extra rewrite responses", seen_rw, exp_rw);
    check(lk_q.size() == 0, "R3 all lookups answered", lk_q.size(), 0);
    finish_run();
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finish_run();
  end
endmodule